// File: doc/BRIEF.md
# Distributed GVT Reduction Engine

This block runs on every node of an optimistic parallel discrete-event simulation. It finds the Global Virtual Time without help from the host processor. The host gives the engine three values: its local virtual time, how many messages it has sent, and how many it has received. The engine then swaps words directly with every peer node. Each peer has its own dedicated point-to-point link, modelled here as a valid/ready word channel.

Each round has two parts. In the count part, every node broadcasts its net message balance (sent minus received). It also collects one balance from each peer and adds them into a global in-transit total. A nonzero total means messages are still in flight, so the engine starts a fresh count round. When the total is zero, the time part runs. Every node broadcasts its local time and keeps the unsigned minimum of all the times. Every node sees the same set of words, so every host is handed the same GVT value.

Each round carries an epoch tag. A word from an older or newer round is consumed and dropped. When the host's own counts change during a phase, it pulses an update. The engine then abandons its current round and begins again with the new balance.

Back-pressure rules:
- Outgoing words: an outgoing word to a peer stays valid, with unchanged data, until that peer's ready is seen. A stalled link holds the round open.
- Incoming words: the engine raises ready on a peer link only while it still needs a word from that peer in the current round part.

Top module: `gvt_engine`

## Requirements
- R1: After reset, `gvt_valid`, `gvt_done`, every `tx_valid` bit and every `rx_ready` bit are 0.
- R2: A `host_start` pulse loads the local time and the balance `host_sent - host_recv`. From the next cycle the engine offers a count word to every peer. Word layout: bit 68 is the kind (0 = count, 1 = time), bits 67:64 are the epoch, bits 63:0 are the payload. A count payload is the 32-bit balance sign-extended. Each `tx_valid` bit stays high with `tx_data` unchanged until its `tx_ready` is seen.
- R3: The engine takes at most one word per peer in each round part. After a matching word is taken, that peer's `rx_ready` drops. A word with the wrong epoch or the wrong kind is consumed without effect, and `rx_ready` for that peer stays high.
- R4: The in-transit total is the local balance plus every peer's count payload bits 31:0, in 32-bit two's complement with wraparound. If the total is nonzero, a new count round starts with the epoch incremented by one (modulo 16).
- R5: If the total is zero, the engine offers a time word with the same epoch to every peer. The result is the unsigned minimum of the local time and all peer times. The all-ones time means the node has no pending events, so it wins only when every time is all-ones.
- R6: One cycle after the edge that completes the last handshake of the time part, `gvt_value` holds the minimum, `gvt_valid` is 1, and `gvt_done` is high for exactly one cycle.
- R7: A `host_update` pulse outside the idle state reloads the balance, increments the epoch and restarts a count round. In the idle state, `host_update` has no effect.
- R8: `gvt_valid` stays set after a result until the next `host_start`, which clears it on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_start | input | 1 | Pulse: a new GVT phase begins; load time and counts |
| host_update | input | 1 | Pulse: the host's counts changed; reload them and restart |
| host_time | input | 64 | Local virtual time, sampled on `host_start` |
| host_sent | input | 32 | Messages sent by this node |
| host_recv | input | 32 | Messages received by this node |
| tx_valid | output | NODES-1 (7) | Per-peer outgoing word valid |
| tx_ready | input | NODES-1 (7) | Per-peer outgoing link ready |
| tx_data | output | 69 | Outgoing word, shared by all peers |
| rx_valid | input | NODES-1 (7) | Per-peer incoming word valid |
| rx_ready | output | NODES-1 (7) | Per-peer incoming ready |
| rx_data | input | 69*(NODES-1) (483) | Incoming words, peer p in bits p*69 upward |
| gvt_value | output | 64 | Computed global virtual time |
| gvt_valid | output | 1 | `gvt_value` is current for this phase |
| gvt_done | output | 1 | One-cycle pulse when a result is committed |

## Verification
Each result has a known arrival cycle:
- Count words are valid in the cycle after a start or update edge.
- Time words, or a retried count round, appear two cycles after the edge that takes the last count word. One cycle is spent checking for zero; the next cycle starts the new part.
- The GVT result and `gvt_done` appear exactly one cycle after the edge that takes the last time word.
- The valid flag clears one cycle after a start edge.

The bench drives all inputs at falling edges and reads each peer's ready there to know which handshakes the next rising edge completes. It samples at the falling edge after the expected register update. It confirms that `gvt_done` is still low one falling edge earlier. A scoreboard queue matches each `gvt_done` to the minimum the driver pushed.

// File: rtl/gvt_pkg.sv
package gvt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNTS,
    ST_CHECK,
    ST_TIMES,
    ST_DONE
  } state_e;

  localparam logic KIND_COUNT = 1'b0;
  localparam logic KIND_TIME  = 1'b1;

endpackage

// File: rtl/gvt_tx_track.sv
module gvt_tx_track #(
  parameter int PEERS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic [PEERS-1:0] tx_ready,
  output logic [PEERS-1:0] tx_valid,
  output logic             all_sent
);

  logic [PEERS-1:0] sent_q;

  assign tx_valid = active ? ~sent_q : '0;
  assign all_sent = &sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
    end else if (clear) begin
      sent_q <= '0;
    end else begin
      sent_q <= sent_q | (tx_valid & tx_ready);
    end
  end

endmodule

// File: rtl/gvt_rx_filter.sv
module gvt_rx_filter #(
  parameter int PEERS   = 7,
  parameter int EPOCH_W = 4,
  localparam int HDR_W  = EPOCH_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   active,
  input  logic                   want_kind,
  input  logic [EPOCH_W-1:0]     epoch,
  input  logic [PEERS-1:0]       rx_valid,
  input  logic [PEERS*HDR_W-1:0] rx_hdr,
  output logic [PEERS-1:0]       rx_ready,
  output logic [PEERS-1:0]       take,
  output logic                   all_got
);

  logic [PEERS-1:0] got_q;

  assign rx_ready = active ? ~got_q : '0;
  assign all_got  = &got_q;

  for (genvar p = 0; p < PEERS; p++) begin : g_peer
    logic [HDR_W-1:0] hdr;
    assign hdr     = rx_hdr[p*HDR_W +: HDR_W];
    assign take[p] = rx_valid[p] && rx_ready[p] &&
                     (hdr[EPOCH_W] == want_kind) &&
                     (hdr[EPOCH_W-1:0] == epoch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
    end else if (clear) begin
      got_q <= '0;
    end else begin
      got_q <= got_q | take;
    end
  end

endmodule

// File: rtl/gvt_reduce.sv
module gvt_reduce #(
  parameter int PEERS  = 7,
  parameter int TIME_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic [PEERS-1:0]        take,
  input  logic [PEERS*TIME_W-1:0] rx_pay,
  output logic [CNT_W-1:0]        cnt_sum,
  output logic [TIME_W-1:0]       time_min
);

  always_comb begin
    cnt_sum  = '0;
    time_min = '1;
    for (int p = 0; p < PEERS; p++) begin
      if (take[p]) begin
        cnt_sum = cnt_sum + rx_pay[p*TIME_W +: CNT_W];
        if (rx_pay[p*TIME_W +: TIME_W] < time_min) begin
          time_min = rx_pay[p*TIME_W +: TIME_W];
        end
      end
    end
  end

endmodule

// File: rtl/gvt_engine.sv
module gvt_engine
  import gvt_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int TIME_W  = 64,
  parameter int CNT_W   = 32,
  parameter int EPOCH_W = 4,
  localparam int PEERS  = NODES - 1,
  localparam int HDR_W  = EPOCH_W + 1,
  localparam int WORD_W = HDR_W + TIME_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_start,
  input  logic                    host_update,
  input  logic [TIME_W-1:0]       host_time,
  input  logic [CNT_W-1:0]        host_sent,
  input  logic [CNT_W-1:0]        host_recv,
  output logic [PEERS-1:0]        tx_valid,
  input  logic [PEERS-1:0]        tx_ready,
  output logic [WORD_W-1:0]       tx_data,
  input  logic [PEERS-1:0]        rx_valid,
  output logic [PEERS-1:0]        rx_ready,
  input  logic [PEERS*WORD_W-1:0] rx_data,
  output logic [TIME_W-1:0]       gvt_value,
  output logic                    gvt_valid,
  output logic                    gvt_done
);

  localparam logic [EPOCH_W-1:0] EPOCH_ONE = 1;

  state_e              state_q;
  logic [EPOCH_W-1:0]  epoch_q;
  logic [CNT_W-1:0]    net_q;
  logic [CNT_W-1:0]    acc_q;
  logic [TIME_W-1:0]   time_q;
  logic [TIME_W-1:0]   min_q;
  logic [TIME_W-1:0]   gvt_q;
  logic                valid_q;
  logic                done_q;

  logic [CNT_W-1:0]        net_new;
  logic                    upd;
  logic                    clear;
  logic                    active;
  logic                    kind_now;
  logic                    all_sent;
  logic                    all_got;
  logic [PEERS-1:0]        take;
  logic [PEERS*HDR_W-1:0]  rx_hdr;
  logic [PEERS*TIME_W-1:0] rx_pay;
  logic [CNT_W-1:0]        cnt_sum;
  logic [TIME_W-1:0]       time_min;
  logic [TIME_W-1:0]       pay_out;

  assign net_new  = host_sent - host_recv;
  assign upd      = host_update && !host_start && (state_q != ST_IDLE);
  assign clear    = host_start || upd || (state_q == ST_CHECK);
  assign active   = (state_q == ST_COUNTS) || (state_q == ST_TIMES);
  assign kind_now = (state_q == ST_TIMES) ? KIND_TIME : KIND_COUNT;

  for (genvar p = 0; p < PEERS; p++) begin : g_split
    assign rx_hdr[p*HDR_W +: HDR_W]   = rx_data[p*WORD_W + TIME_W +: HDR_W];
    assign rx_pay[p*TIME_W +: TIME_W] = rx_data[p*WORD_W +: TIME_W];
  end

  always_comb begin
    if (state_q == ST_TIMES) begin
      pay_out = time_q;
    end else begin
      pay_out = {{(TIME_W-CNT_W){net_q[CNT_W-1]}}, net_q};
    end
  end

  assign tx_data = {kind_now, epoch_q, pay_out};

  gvt_tx_track #(.PEERS(PEERS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .active   (active),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .all_sent (all_sent)
  );

  gvt_rx_filter #(.PEERS(PEERS), .EPOCH_W(EPOCH_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .active    (active),
    .want_kind (kind_now),
    .epoch     (epoch_q),
    .rx_valid  (rx_valid),
    .rx_hdr    (rx_hdr),
    .rx_ready  (rx_ready),
    .take      (take),
    .all_got   (all_got)
  );

  gvt_reduce #(.PEERS(PEERS), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_red (
    .take     (take),
    .rx_pay   (rx_pay),
    .cnt_sum  (cnt_sum),
    .time_min (time_min)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      epoch_q <= '0;
      net_q   <= '0;
      acc_q   <= '0;
      time_q  <= '0;
      min_q   <= '0;
      gvt_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (host_start) begin
        time_q  <= host_time;
        net_q   <= net_new;
        acc_q   <= net_new;
        epoch_q <= epoch_q + EPOCH_ONE;
        valid_q <= 1'b0;
        state_q <= ST_COUNTS;
      end else if (upd) begin
        net_q   <= net_new;
        acc_q   <= net_new;
        epoch_q <= epoch_q + EPOCH_ONE;
        state_q <= ST_COUNTS;
      end else begin
        case (state_q)
          ST_COUNTS: begin
            acc_q <= acc_q + cnt_sum;
            if (all_sent && all_got) state_q <= ST_CHECK;
          end
          ST_CHECK: begin
            if (acc_q == '0) begin
              min_q   <= time_q;
              state_q <= ST_TIMES;
            end else begin
              acc_q   <= net_q;
              epoch_q <= epoch_q + EPOCH_ONE;
              state_q <= ST_COUNTS;
            end
          end
          ST_TIMES: begin
            if (all_sent && all_got) begin
              gvt_q   <= min_q;
              valid_q <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else if (time_min < min_q) begin
              min_q <= time_min;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign gvt_value = gvt_q;
  assign gvt_valid = valid_q;
  assign gvt_done  = done_q;

endmodule

// File: rtl/gvt_engine_chk.sv
module gvt_engine_chk
  import gvt_pkg::*;
#(
  parameter int PEERS  = 7,
  parameter int WORD_W = 69
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_start,
  input logic              host_update,
  input logic [PEERS-1:0]  tx_valid,
  input logic [PEERS-1:0]  tx_ready,
  input logic [WORD_W-1:0] tx_data,
  input logic              gvt_valid,
  input logic              gvt_done,
  input state_e            state_q
);

  for (genvar p = 0; p < PEERS; p++) begin : g_hold
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[p] && !tx_ready[p] && !host_start && !host_update
      |=> tx_valid[p] && $stable(tx_data)); // R2
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (tx_valid == '0) && !gvt_done); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gvt_done |=> !gvt_done); // R6

  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    gvt_done |-> gvt_valid && (state_q == ST_DONE)); // R6

  AST_UPD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    host_update && !host_start && (state_q != ST_IDLE) |=> state_q == ST_COUNTS); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    host_start |=> !gvt_valid && (state_q == ST_COUNTS)); // R8

endmodule

bind gvt_engine gvt_engine_chk #(.PEERS(PEERS), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_gvt_engine.sv
`timescale 1ns/1ps
module test_gvt_engine;

  localparam int PEERS  = 7;
  localparam int WORD_W = 69;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    host_start = 1'b0;
  logic                    host_update = 1'b0;
  logic [63:0]             host_time = '0;
  logic [31:0]             host_sent = '0;
  logic [31:0]             host_recv = '0;
  logic [PEERS-1:0]        tx_valid;
  logic [PEERS-1:0]        tx_ready = '1;
  logic [WORD_W-1:0]       tx_data;
  logic [PEERS-1:0]        rx_valid = '0;
  logic [PEERS-1:0]        rx_ready;
  logic [PEERS*WORD_W-1:0] rx_data = '0;
  logic [63:0]             gvt_value;
  logic                    gvt_valid;
  logic                    gvt_done;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  logic [WORD_W-1:0] wv [PEERS];
  logic [3:0] ep, ep2;

  always #5 clk = ~clk;

  gvt_engine i_gvt_engine (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && gvt_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual done with %h expected no result", gvt_value);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if (gvt_value !== e || gvt_valid !== 1'b1) begin
          errors++;
          $display("FAIL R5: actual %h/%b expected %h/1", gvt_value, gvt_valid, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  function automatic logic [WORD_W-1:0] mk_count(input logic [3:0] e, input logic [31:0] v);
    return {1'b0, e, {32{v[31]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] mk_time(input logic [3:0] e, input logic [63:0] t);
    return {1'b1, e, t};
  endfunction

  task automatic pulse_start(input logic [63:0] t, input logic [31:0] s, input logic [31:0] r);
    @(negedge clk);
    host_start = 1'b1; host_time = t; host_sent = s; host_recv = r;
    @(negedge clk);
    host_start = 1'b0;
  endtask

  task automatic pulse_update(input logic [31:0] s, input logic [31:0] r);
    @(negedge clk);
    host_update = 1'b1; host_sent = s; host_recv = r;
    @(negedge clk);
    host_update = 1'b0;
  endtask

  task automatic wait_tx(input logic kind, output logic [3:0] e);
    int n;
    n = 0;
    while (!(|tx_valid && tx_data[68] == kind) && n < 50) begin
      @(negedge clk);
      n++;
    end
    e = tx_data[67:64];
    chk("R2 tx word offered", {63'd0, |tx_valid}, 64'd1);
  endtask

  // drive words on the masked peers; handshake completes on the edge after ready seen
  task automatic send_words(input logic [WORD_W-1:0] w [PEERS], input logic [PEERS-1:0] mask);
    logic [PEERS-1:0] pend, rdy;
    int n;
    pend = mask;
    n = 0;
    @(negedge clk);
    for (int p = 0; p < PEERS; p++) begin
      if (pend[p]) begin
        rx_valid[p] = 1'b1;
        rx_data[p*WORD_W +: WORD_W] = w[p];
      end
    end
    while (pend != '0 && n < 100) begin
      rdy = rx_ready & pend;
      @(negedge clk);
      for (int p = 0; p < PEERS; p++) begin
        if (rdy[p]) begin
          pend[p] = 1'b0;
          rx_valid[p] = 1'b0;
        end
      end
      n++;
    end
    rx_valid = '0;
  endtask

  task automatic send_one(input int p, input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] one [PEERS];
    for (int q = 0; q < PEERS; q++) one[q] = w;
    send_words(one, PEERS'(1) << p);
  endtask

  task automatic times_expect(input logic [WORD_W-1:0] w [PEERS], input logic [63:0] e);
    exp_q.push_back(e);
    send_words(w, '1);
    chk("R6 no result before latency", {63'd0, gvt_done}, 64'd0);
    @(negedge clk);
    chk("R6 done one cycle after last time word", {63'd0, gvt_done}, 64'd1);
    chk("R6 value", gvt_value, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gvt_valid", {63'd0, gvt_valid}, 64'd0);
    chk("R1 gvt_done", {63'd0, gvt_done}, 64'd0);
    chk("R1 tx_valid", {57'd0, tx_valid}, 64'd0);
    chk("R1 rx_ready", {57'd0, rx_ready}, 64'd0);

    // R7: update while idle is ignored
    pulse_update(32'd9, 32'd1);
    @(negedge clk);
    chk("R7 idle update tx_valid", {57'd0, tx_valid}, 64'd0);
    chk("R7 idle update rx_ready", {57'd0, rx_ready}, 64'd0);

    // basic round
    pulse_start(64'd1000, 32'd5, 32'd3);
    wait_tx(1'b0, ep);
    chk("R2 count payload", tx_data[63:0], 64'd2);
    chk("R2 all peers offered", {57'd0, tx_valid}, {57'd0, 7'h7F});
    chk("R4 first epoch", {60'd0, ep}, 64'd1);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, (p == 0) ? -32'sd2 : 32'd0);
    send_words(wv, '1);
    wait_tx(1'b1, ep2);
    chk("R5 time word epoch", {60'd0, ep2}, {60'd0, ep});
    chk("R5 time payload", tx_data[63:0], 64'd1000);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, (p == 3) ? 64'd900 : 64'd2000 + 64'(p));
    times_expect(wv, 64'd900);
    repeat (3) @(negedge clk);
    chk("R8 valid held", {63'd0, gvt_valid}, 64'd1);

    // nonzero total then retry with wraparound values
    pulse_start(64'd500, 32'd10, 32'd4);
    chk("R8 start clears valid", {63'd0, gvt_valid}, 64'd0);
    wait_tx(1'b0, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, (p == 1) ? -32'sd5 : 32'd0);
    send_words(wv, '1);
    wait_tx(1'b0, ep2);
    chk("R4 retry epoch", {60'd0, ep2}, {60'd0, ep + 4'd1});
    chk("R4 retry payload", tx_data[63:0], 64'd6);
    wv[0] = mk_count(ep2, 32'h7FFF_FFFF);
    wv[1] = mk_count(ep2, 32'h8000_0001);
    wv[2] = mk_count(ep2, 32'd3);
    wv[3] = mk_count(ep2, -32'sd9);
    for (int p = 4; p < PEERS; p++) wv[p] = mk_count(ep2, 32'd0);
    send_words(wv, '1);
    wait_tx(1'b1, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, (p == 2) ? 64'd700 : '1);
    times_expect(wv, 64'd500);

    // all-ones: local idle, one peer slightly smaller
    pulse_start('1, 32'd0, 32'd0);
    wait_tx(1'b0, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, 32'd0);
    send_words(wv, '1);
    wait_tx(1'b1, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, (p == 6) ? 64'hFFFF_FFFF_FFFF_FFFE : '1);
    times_expect(wv, 64'hFFFF_FFFF_FFFF_FFFE);

    // all nodes idle
    pulse_start('1, 32'd0, 32'd0);
    wait_tx(1'b0, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, 32'd0);
    send_words(wv, '1);
    wait_tx(1'b1, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, '1);
    times_expect(wv, '1);

    // stale epoch and wrong kind are discarded
    pulse_start(64'd300, 32'd1, 32'd1);
    wait_tx(1'b0, ep);
    send_one(0, mk_count(ep + 4'd1, 32'd99));
    chk("R3 stale epoch keeps ready", {63'd0, rx_ready[0]}, 64'd1);
    send_one(0, mk_time(ep, 64'd5));
    chk("R3 wrong kind keeps ready", {63'd0, rx_ready[0]}, 64'd1);
    send_one(1, mk_count(ep, 32'd0));
    chk("R3 ready drops after word", {63'd0, rx_ready[1]}, 64'd0);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, 32'd0);
    send_words(wv, 7'h7D);
    wait_tx(1'b1, ep2);
    chk("R3 discarded count ignored", {60'd0, ep2}, {60'd0, ep});
    send_one(2, mk_time(ep + 4'd1, 64'd1));
    chk("R3 stale time keeps ready", {63'd0, rx_ready[2]}, 64'd1);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, 64'd400);
    times_expect(wv, 64'd300);

    // host update restarts a count round
    pulse_start(64'd800, 32'd3, 32'd0);
    wait_tx(1'b0, ep);
    send_one(0, mk_count(ep, -32'sd3));
    pulse_update(32'd3, 32'd1);
    wait_tx(1'b0, ep2);
    chk("R7 update epoch", {60'd0, ep2}, {60'd0, ep + 4'd1});
    chk("R7 update payload", tx_data[63:0], 64'd2);
    chk("R7 peer0 ready again", {63'd0, rx_ready[0]}, 64'd1);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep2, (p == 5) ? -32'sd2 : 32'd0);
    send_words(wv, '1);
    wait_tx(1'b1, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep, 64'd850 + 64'(p));
    times_expect(wv, 64'd800);

    // back-pressure on one outgoing link
    tx_ready = 7'b1101111;
    pulse_start(64'd50, 32'd0, 32'd0);
    wait_tx(1'b0, ep);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_count(ep, 32'd0);
    send_words(wv, '1);
    repeat (3) @(negedge clk);
    chk("R2 stalled peer still valid", {57'd0, tx_valid}, {57'd0, 7'b0010000});
    chk("R2 stalled word unchanged", {55'd0, tx_data[68:64], tx_data[3:0]}, {55'd0, 1'b0, ep, 4'd0});
    tx_ready = '1;
    wait_tx(1'b1, ep2);
    for (int p = 0; p < PEERS; p++) wv[p] = mk_time(ep2, 64'd60);
    times_expect(wv, 64'd50);

    repeat (5) @(negedge clk);
    chk("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finish_sim();
  end

endmodule